// File: doc/BRIEF.md
# Instruction Dispatch Group Former

This block sits after instruction pre-decode and bundles the incoming instruction stream into dispatch groups of up to five slots. Every instruction arrives already tagged with an execution-unit class, two count-register flags (writes it / branches through it), store and load flags and a short address tag. The former appends instructions to an open group in arrival order. It closes the group when the next instruction would exceed a per-class quota, would land a non-branch in the last slot, or would form a structural hazard with something already in the group. A branch is always the last member of its group, so accepting one closes the group.

A closed group is written into a single output register and offered on a valid/ready stream. A group closed by a hazard has all of its unused slots filled with no-op fillers. The output keeps its valid flag and its contents stable until the consumer takes it with `out_ready`. While the output register is full and not being drained, `in_ready` stays low. `in_ready` is a combinational function of the presented instruction's fields and the open group. An instruction that does not fit sees `in_ready` low for one cycle, in which the open group is emitted. It is accepted in a later cycle, into the next group. A producer must hold an offered instruction stable until it is accepted. A `flush` pulse discards the open group.

Top module: `dispatch_group_former`

## Requirements
- R1: After reset `out_valid` is 0, the open group is empty, and `in_ready` is 1 while `flush` is low.
- R2: A group holds at most five slots. Accepted instructions fill slots from slot 0 in arrival order. A real slot carries the instruction's class and id on `out_slot_class[3*i +: 3]` and `out_slot_id[8*i +: 8]`.
- R3: The class codes and per-group quotas are: 0 integer (2), 1 floating point (2), 2 load/store (2), 3 condition register (1), 4 vector ALU (1), 5 vector permute (1), 6 branch (1), 7 serialising (1). When an instruction's class quota is already used, the open group is emitted without it and without fillers, and the instruction is accepted into the following group.
- R4: When a branch (class 6) is accepted, the group is emitted in the next cycle with the branch as its highest real slot.
- R5: Only a branch may occupy slot 4. A non-branch offered while four slots are used causes the group to be emitted without it and without fillers.
- R6: A branch with `in_br_ctr` set, offered while the open group holds an instruction with `in_wr_ctr` set, is not placed in that group. The group is emitted with every unused slot marked valid and no-op. Filler slots carry class 0 and id 0 and take no quota.
- R7: A load whose `in_addr` equals that of a store already in the open group causes the same filler-padded emission as R6. A load with a different address is unaffected. When a hazard and a full quota coincide, the padded form is used.
- R8: Quota counts, the count-register-written flag and the store addresses are cleared whenever a group closes. The first instruction of a new group is never refused.
- R9: A group appears on the output the cycle after it closes. `out_valid` and all slot fields then stay unchanged until a cycle with `out_ready` high. While `out_valid` is high and `out_ready` is low, `in_ready` is 0.
- R10: While `flush` is high, `in_ready` is 0 and the open group is discarded. A group already in the output register is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the open group |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_class | input | 3 | Unit class code |
| in_wr_ctr | input | 1 | Instruction writes the count register |
| in_br_ctr | input | 1 | Branch through the count register |
| in_store | input | 1 | Memory store |
| in_load | input | 1 | Memory load |
| in_addr | input | 6 | Address tag compared for equality |
| in_id | input | 8 | Opaque instruction id carried to the output |
| out_valid | output | 1 | Group available |
| out_ready | input | 1 | Consumer takes the group |
| out_slot_valid | output | 5 | Slot occupied (real or filler) |
| out_slot_nop | output | 5 | Slot is a no-op filler |
| out_slot_class | output | 15 | Per-slot class code, 3 bits per slot |
| out_slot_id | output | 40 | Per-slot instruction id, 8 bits per slot |

## Verification
The assertions assume that `in_br_ctr` is only set on branches, and that `in_store` and `in_load` are exclusive and only set on class-2 instructions. They also assume that an offered instruction is held stable until accepted. The stimulus keeps to this. Directed and random instructions are generated with these flags tied to their classes, and `in_valid` and the instruction fields change only after an acceptance. Random back-pressure and occasional flush pulses exercise R9 and R10. Address tags are drawn from four values, so store/load collisions occur often.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int CLS_W   = 3;
  localparam int NUM_CLS = 8;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 3'd0,
    CLS_FLT   = 3'd1,
    CLS_MEM   = 3'd2,
    CLS_CRF   = 3'd3,
    CLS_VEC   = 3'd4,
    CLS_PERM  = 3'd5,
    CLS_BR    = 3'd6,
    CLS_SER   = 3'd7
  } unit_cls_e;

  // Per-group slot budget of each class
  function automatic int unsigned cls_quota(int unsigned c);
    return (c <= 2) ? 2 : 1;
  endfunction
endpackage

// File: rtl/dgf_quota.sv
module dgf_quota #(
  parameter int NUM_CLS = 8,
  parameter int CW      = 2,
  localparam int SELW   = $clog2(NUM_CLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  input  logic [SELW-1:0] cls,
  output logic            full
);
  logic [NUM_CLS-1:0] full_v;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    localparam logic [CW-1:0] LIM = CW'(dgf_pkg::cls_quota(g));
    logic [CW-1:0] used_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         used_q <= '0;
      else if (clr)                       used_q <= '0;
      else if (inc && cls == SELW'(g))    used_q <= used_q + 1'b1;
    end
    assign full_v[g] = (used_q >= LIM);
  end

  assign full = full_v[cls];

  // R3: an instruction is never counted into a class whose budget is spent
  assert_quota_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !full);
endmodule

// File: rtl/dgf_hazard.sv
module dgf_hazard #(
  parameter int SLOTS = 5,
  parameter int AW    = 6,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [SW-1:0] slot,
  input  logic          wr_ctr,
  input  logic          store,
  input  logic          br_ctr,
  input  logic          load,
  input  logic [AW-1:0] addr,
  output logic          hazard
);
  logic             ctr_seen_q;
  logic [SLOTS-1:0] hit_v;

  always_ff @(posedge clk) begin
    if (!rst_n)                 ctr_seen_q <= 1'b0;
    else if (clr)               ctr_seen_q <= 1'b0;
    else if (upd && wr_ctr)     ctr_seen_q <= 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_st
    logic          st_vld_q;
    logic [AW-1:0] st_tag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_vld_q <= 1'b0;
        st_tag_q <= '0;
      end else if (clr) begin
        st_vld_q <= 1'b0;
      end else if (upd && slot == SW'(g)) begin
        st_vld_q <= store;
        st_tag_q <= addr;
      end
    end
    assign hit_v[g] = st_vld_q && (st_tag_q == addr);
  end

  assign hazard = (br_ctr && ctr_seen_q) || (load && |hit_v);

  // R6 / R7: nothing that completes a hazard is ever appended to the group
  assert_hazard_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !hazard);
endmodule

// File: rtl/dgf_slots.sv
module dgf_slots #(
  parameter int SLOTS = 5,
  parameter int IW    = 8,
  parameter int CLS_W = 3,
  localparam int CNTW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   push,
  input  logic [CLS_W-1:0]       cls,
  input  logic [IW-1:0]          id,
  output logic [CNTW-1:0]        cnt,
  output logic [SLOTS*CLS_W-1:0] cls_flat,
  output logic [SLOTS*IW-1:0]    id_flat
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (push)  cnt_q <= cnt_q + 1'b1;
  end
  assign cnt = cnt_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [CLS_W-1:0] cls_q;
    logic [IW-1:0]    id_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cls_q <= '0;
        id_q  <= '0;
      end else if (push && !clr && cnt_q == CNTW'(g)) begin
        cls_q <= cls;
        id_q  <= id;
      end
    end
    assign cls_flat[g*CLS_W +: CLS_W] = cls_q;
    assign id_flat[g*IW +: IW]        = id_q;
  end

  // R5: a non-branch is never stored beyond the second-to-last slot
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNTW'(SLOTS - 1)));
endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
  import dgf_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int IW    = 8,
  parameter int AW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CLS_W-1:0]       in_class,
  input  logic                   in_wr_ctr,
  input  logic                   in_br_ctr,
  input  logic                   in_store,
  input  logic                   in_load,
  input  logic [AW-1:0]          in_addr,
  input  logic [IW-1:0]          in_id,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SLOTS-1:0]       out_slot_valid,
  output logic [SLOTS-1:0]       out_slot_nop,
  output logic [SLOTS*CLS_W-1:0] out_slot_class,
  output logic [SLOTS*IW-1:0]    out_slot_id
);
  localparam int CNTW = $clog2(SLOTS + 1);
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [CNTW-1:0]        grp_cnt;
  logic [SLOTS*CLS_W-1:0] grp_cls;
  logic [SLOTS*IW-1:0]    grp_id;
  logic q_full, hazard, is_br, last_blk, fits, out_space, go;
  logic accept, close_br, close_early, pad, grp_clr, grp_push, load_out;

  // ---- acceptance decision -------------------------------------------------
  assign is_br       = (in_class == CLS_BR);
  assign last_blk    = (grp_cnt == CNTW'(SLOTS - 1)) && !is_br;
  assign fits        = !hazard && !q_full && !last_blk;
  assign out_space   = !out_valid || out_ready;
  assign go          = in_valid && !flush && out_space;
  assign accept      = go && fits;
  assign close_br    = accept && is_br;
  assign close_early = go && !fits;
  assign pad         = close_early && hazard;
  assign grp_clr     = flush || close_br || close_early;
  assign grp_push    = accept && !is_br;
  assign load_out    = close_br || close_early;
  assign in_ready    = !flush && out_space && fits;

  dgf_quota #(.NUM_CLS(NUM_CLS), .CW(2)) u_quota (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (grp_clr),
    .inc  (grp_push),
    .cls  (in_class),
    .full (q_full)
  );

  dgf_hazard #(.SLOTS(SLOTS), .AW(AW)) u_hazard (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (grp_clr),
    .upd   (grp_push),
    .slot  (grp_cnt[SW-1:0]),
    .wr_ctr(in_wr_ctr),
    .store (in_store),
    .br_ctr(in_br_ctr),
    .load  (in_load),
    .addr  (in_addr),
    .hazard(hazard)
  );

  dgf_slots #(.SLOTS(SLOTS), .IW(IW), .CLS_W(CLS_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (grp_clr),
    .push    (grp_push),
    .cls     (in_class),
    .id      (in_id),
    .cnt     (grp_cnt),
    .cls_flat(grp_cls),
    .id_flat (grp_id)
  );

  // ---- closed-group assembly ----------------------------------------------
  logic [SLOTS-1:0]       held_v, here_v, nxt_sv, nxt_nop;
  logic [SLOTS*CLS_W-1:0] nxt_cls;
  logic [SLOTS*IW-1:0]    nxt_id;

  for (genvar g = 0; g < SLOTS; g++) begin : g_asm
    assign held_v[g]  = CNTW'(g) < grp_cnt;
    assign here_v[g]  = close_br && (CNTW'(g) == grp_cnt);
    assign nxt_sv[g]  = held_v[g] | here_v[g] | pad;
    assign nxt_nop[g] = pad & ~held_v[g];
    assign nxt_cls[g*CLS_W +: CLS_W] = held_v[g] ? grp_cls[g*CLS_W +: CLS_W]
                                     : (here_v[g] ? in_class : '0);
    assign nxt_id[g*IW +: IW]        = held_v[g] ? grp_id[g*IW +: IW]
                                     : (here_v[g] ? in_id : '0);
  end

  // ---- output register ------------------------------------------------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_slot_valid <= '0;
      out_slot_nop   <= '0;
      out_slot_class <= '0;
      out_slot_id    <= '0;
    end else if (load_out) begin
      out_valid      <= 1'b1;
      out_slot_valid <= nxt_sv;
      out_slot_nop   <= nxt_nop;
      out_slot_class <= nxt_cls;
      out_slot_id    <= nxt_id;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

  // ---- checks ---------------------------------------------------------------
  assert_flush_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (grp_cnt == '0));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_valid) &&
      $stable(out_slot_nop) && $stable(out_slot_class) && $stable(out_slot_id)));

  assert_branch_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && is_br) |=> (out_valid && grp_cnt == '0));

  assert_last_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_slot_valid[SLOTS-1] && !out_slot_nop[SLOTS-1]) |->
      (out_slot_class[(SLOTS-1)*CLS_W +: CLS_W] == CLS_BR));
endmodule

// File: tb/test_dispatch_group_former.sv
module test_dispatch_group_former;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 5;
  localparam int IW     = 8;
  localparam int AW     = 6;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_class = '0;
  logic in_wr_ctr = 1'b0, in_br_ctr = 1'b0, in_store = 1'b0, in_load = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [IW-1:0] in_id = '0;
  logic out_valid, out_ready = 1'b1;
  logic [SLOTS-1:0] out_slot_valid, out_slot_nop;
  logic [SLOTS*3-1:0] out_slot_class;
  logic [SLOTS*IW-1:0] out_slot_id;

  always #(PERIOD/2) clk = ~clk;

  dispatch_group_former #(.SLOTS(SLOTS), .IW(IW), .AW(AW)) i_dispatch_group_former (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
    .in_wr_ctr(in_wr_ctr), .in_br_ctr(in_br_ctr), .in_store(in_store),
    .in_load(in_load), .in_addr(in_addr), .in_id(in_id),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_slot_valid(out_slot_valid), .out_slot_nop(out_slot_nop),
    .out_slot_class(out_slot_class), .out_slot_id(out_slot_id));

  typedef struct { int cls; bit wr; bit br; bit st; bit ld; int addr; } ins_t;

  int vectors = 0, miscompares = 0;
  ins_t dq[$];
  // reference group contents
  int g_cls[$], g_id[$], g_wr[$], g_st[$], g_addr[$];
  // reference output register
  bit m_ov = 0;
  int m_sv[SLOTS], m_nop[SLOTS], m_cls[SLOTS], m_id[SLOTS];
  string m_req = "R2";

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int quota(int c);
    return (c <= 2) ? 2 : 1;
  endfunction

  function automatic ins_t mk(int c, bit wr = 0, bit br = 0, bit st = 0, bit ld = 0, int a = 0);
    ins_t t;
    t.cls = c; t.wr = wr; t.br = br; t.st = st; t.ld = ld; t.addr = a;
    return t;
  endfunction

  task automatic emit(bit pad, string req);
    for (int i = 0; i < SLOTS; i++) begin
      if (i < g_cls.size()) begin
        m_sv[i] = 1; m_nop[i] = 0; m_cls[i] = g_cls[i]; m_id[i] = g_id[i];
      end else if (pad) begin
        m_sv[i] = 1; m_nop[i] = 1; m_cls[i] = 0; m_id[i] = 0;
      end else begin
        m_sv[i] = 0; m_nop[i] = 0; m_cls[i] = 0; m_id[i] = 0;
      end
    end
    m_ov = 1; m_req = req;
    g_cls.delete(); g_id.delete(); g_wr.delete(); g_st.delete(); g_addr.delete();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int next_id = 1;
    bit accepted = 0;
    // directed sequences
    dq.push_back(mk(0)); dq.push_back(mk(0)); dq.push_back(mk(0)); dq.push_back(mk(6));   // R3
    dq.push_back(mk(2,0,0,0,1,0)); dq.push_back(mk(2,0,0,0,1,1));
    dq.push_back(mk(2,0,0,0,1,2)); dq.push_back(mk(6));                                  // R3 loads
    dq.push_back(mk(0)); dq.push_back(mk(0)); dq.push_back(mk(1)); dq.push_back(mk(1));
    dq.push_back(mk(3)); dq.push_back(mk(6));                                            // R5
    dq.push_back(mk(0)); dq.push_back(mk(1)); dq.push_back(mk(2,0,0,1,0,3));
    dq.push_back(mk(3)); dq.push_back(mk(6));                                            // R2 R4 full
    dq.push_back(mk(0,1)); dq.push_back(mk(6,0,1)); dq.push_back(mk(6,0,1));              // R6 R8
    dq.push_back(mk(2,0,0,1,0,1)); dq.push_back(mk(2,0,0,0,1,2)); dq.push_back(mk(4));
    dq.push_back(mk(2,0,0,0,1,1)); dq.push_back(mk(6));                                  // R7
    dq.push_back(mk(0)); dq.push_back(mk(1)); dq.push_back(mk(-1));
    dq.push_back(mk(5)); dq.push_back(mk(6));                                            // R10
    dq.push_back(mk(7)); dq.push_back(mk(7)); dq.push_back(mk(6));                        // R3 serial

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit directed, haz, qfull, lastb, fits, space, expr;
      int cnt;
      string rq;
      @(negedge clk);
      directed = (dq.size() > 0);
      flush = 1'b0;
      if (accepted) in_valid = 1'b0;
      accepted = 0;
      if (!in_valid) begin
        ins_t t;
        bit take = 0;
        if (directed) begin
          t = dq.pop_front();
          if (t.cls < 0) flush = 1'b1; else take = 1;
        end else if ($urandom % 10 < 7) begin
          int r = $urandom % 10;
          t = mk(r < 8 ? r : 2);
          t.wr = ($urandom % 5 == 0);
          t.br = (t.cls == 6) && ($urandom % 2 == 1);
          if (t.cls == 2) begin
            t.st = $urandom % 2; t.ld = !t.st; t.addr = $urandom % 4;
          end
          take = 1;
        end
        if (take) begin
          in_class = 3'(t.cls); in_wr_ctr = t.wr; in_br_ctr = t.br;
          in_store = t.st; in_load = t.ld; in_addr = AW'(t.addr);
          in_id = IW'(next_id); next_id++;
          in_valid = 1'b1;
        end
      end
      if (!directed) begin
        out_ready = ($urandom % 4 != 0);
        if ($urandom % 40 == 0) flush = 1'b1;
      end else begin
        out_ready = 1'b1;
      end
      #1;
      // reference decision
      haz = 0; cnt = 0;
      for (int i = 0; i < g_cls.size(); i++) begin
        if (in_br_ctr && g_wr[i] != 0) haz = 1;
        if (in_load && g_st[i] != 0 && g_addr[i] == int'(in_addr)) haz = 1;
        if (g_cls[i] == int'(in_class)) cnt++;
      end
      qfull = (cnt >= quota(int'(in_class)));
      lastb = (g_cls.size() == SLOTS - 1) && (in_class != 3'd6);
      fits  = !haz && !qfull && !lastb;
      space = !m_ov || out_ready;
      expr  = !flush && space && fits;
      rq = flush ? "R10" : !space ? "R9" : (haz && in_br_ctr) ? "R6" : haz ? "R7" :
           qfull ? "R3" : lastb ? "R5" : "R8";
      check(in_ready == expr, rq, "in_ready", in_ready, expr);
      check(out_valid == m_ov, "R9", "out_valid", out_valid, m_ov);
      if (m_ov) begin
        for (int i = 0; i < SLOTS; i++) begin
          check(out_slot_valid[i] == m_sv[i][0], m_req, $sformatf("slot %0d valid", i), out_slot_valid[i], m_sv[i]);
          check(out_slot_nop[i] == m_nop[i][0], m_req, $sformatf("slot %0d nop", i), out_slot_nop[i], m_nop[i]);
          if (m_sv[i] != 0) begin
            check(int'(out_slot_class[i*3 +: 3]) == m_cls[i], m_req, $sformatf("slot %0d class", i),
                  out_slot_class[i*3 +: 3], m_cls[i]);
            check(int'(out_slot_id[i*IW +: IW]) == m_id[i], m_req, $sformatf("slot %0d id", i),
                  out_slot_id[i*IW +: IW], m_id[i]);
          end
        end
      end
      // reference update for the coming edge
      if (m_ov && out_ready) m_ov = 0;
      if (flush) begin
        g_cls.delete(); g_id.delete(); g_wr.delete(); g_st.delete(); g_addr.delete();
      end else if (in_valid && space) begin
        if (fits) begin
          accepted = 1;
          g_cls.push_back(int'(in_class)); g_id.push_back(int'(in_id));
          g_wr.push_back(int'(in_wr_ctr)); g_st.push_back(int'(in_store));
          g_addr.push_back(int'(in_addr));
          if (in_class == 3'd6) emit(0, g_cls.size() == SLOTS ? "R2" : "R4");
        end else begin
          emit(haz, rq);
        end
      end
    end
    summary();
    $finish;
  end
endmodule